// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Mapper

This block is the bank controller of a cartridge on an 8-bit console bus. It takes its bank number from the address of a CPU write, not from the data. A CPU write anywhere from $8000 to $FFFF stores CPU address bits A3..A0 in a four-bit bank register. The data bus is not even an input. No read and no write below $8000 changes the register. That includes writes to $6000-$7FFF, which software may issue as well.

Bits 3..2 of the register choose the 16 KB program bank seen at CPU $8000-$BFFF. CPU $C000-$FFFF always shows the last program bank. Bits 1..0 choose the 8 KB character bank seen at PPU $0000-$1FFF. With the default parameters this covers 64 KB of program ROM and 32 KB of character ROM. The ROM output is never combined with the stored value, so there are no bus conflicts. A static strap picks horizontal or vertical nametable arrangement, and no register can change it.

Top module: `cart_addr_bank_map`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released, the bank register is 0. A read at $8000 then gives `prg_addr` 0x0000, and `chr_addr` for PPU address 0 is 0x0000.
- R2: A clock edge with `cpu_wr` high and `cpu_addr[15]` high stores `cpu_addr[3:0]` in the bank register. Bits 14..4 of that address have no effect on the stored value.
- R3: `chr_addr` = {bank[1:0], `ppu_addr[12:0]`}.
- R4: For CPU addresses $8000-$BFFF, `prg_addr` = {bank[3:2], `cpu_addr[13:0]`}.
- R5: For CPU addresses $C000-$FFFF, `prg_addr` = {2'b11, `cpu_addr[13:0]`}, whatever the register holds.
- R6: A write with `cpu_addr[15]` low, including any address in $6000-$7FFF, leaves the bank register unchanged.
- R7: `prg_en` is 1 exactly when `cpu_addr[15]` is 1.
- R8: `nt_sel` equals `ppu_addr[10]` when `mirror_horiz` is 0 (vertical) and equals `ppu_addr[11]` when `mirror_horiz` is 1 (horizontal).
- R9: A cycle with `cpu_wr` low leaves the bank register unchanged, at any address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe, sampled on the clock edge |
| ppu_addr | input | 14 | PPU address |
| mirror_horiz | input | 1 | Mirroring strap: 1 = horizontal, 0 = vertical |
| prg_addr | output | 16 | Program ROM address |
| prg_en | output | 1 | Program ROM enable |
| chr_addr | output | 15 | Character ROM address |
| nt_sel | output | 1 | Nametable select line |

## Verification
The bench writes to addresses whose upper bits 14..4 are nonzero. A design that latched the wrong slice of the address would then store the wrong bank. It also writes to $6003 and $7FFF and reads from $800F. A design that decoded A15 loosely, or that latched on reads, would change banks on those cycles. It reads the fixed window after the register has been loaded with a nonzero program bank, which exposes a decoder that lets the switchable bank leak into $C000-$FFFF. It also drives `ppu_addr` with A10 and A11 set differently under both strap values, which exposes swapped mirroring.

// File: rtl/cart_addr_bank_map.sv
module cart_addr_bank_map #(
  parameter int PRG_BANK_W = 2,
  parameter int CHR_BANK_W = 2,
  parameter int PRG_WIN_AW = 14,
  parameter int CHR_WIN_AW = 13
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [15:0]                        cpu_addr,
  input  logic                               cpu_wr,
  input  logic [13:0]                        ppu_addr,
  input  logic                               mirror_horiz,
  output logic [PRG_BANK_W+PRG_WIN_AW-1:0]   prg_addr,
  output logic                               prg_en,
  output logic [CHR_BANK_W+CHR_WIN_AW-1:0]   chr_addr,
  output logic                               nt_sel
);
  localparam int BANK_W = PRG_BANK_W + CHR_BANK_W;
  localparam logic [PRG_BANK_W-1:0] LAST_PRG = '1;

  logic [BANK_W-1:0]     bank_q;
  logic [PRG_BANK_W-1:0] prg_bank;
  logic                  bank_ld;

  assign bank_ld = cpu_wr && cpu_addr[15];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bank_q <= '0;
    else if (bank_ld) bank_q <= cpu_addr[BANK_W-1:0];

  assign prg_bank = cpu_addr[14] ? LAST_PRG : bank_q[BANK_W-1:CHR_BANK_W];
  assign prg_addr = {prg_bank, cpu_addr[PRG_WIN_AW-1:0]};
  assign prg_en   = cpu_addr[15];
  assign chr_addr = {bank_q[CHR_BANK_W-1:0], ppu_addr[CHR_WIN_AW-1:0]};
  assign nt_sel   = mirror_horiz ? ppu_addr[11] : ppu_addr[10];
endmodule

module cart_addr_bank_map_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic [13:0] ppu_addr,
  input logic        mirror_horiz,
  input logic [15:0] prg_addr,
  input logic        prg_en,
  input logic [14:0] chr_addr,
  input logic        nt_sel,
  input logic [3:0]  bank_q
);
  always @(negedge clk)
    if (!rst_n) assert_reset_clear_R1: assert (bank_q == 4'd0);

  assert_latch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15]) |=> bank_q == $past(cpu_addr[3:0]));

  assert_chr_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr == {bank_q[1:0], ppu_addr[12:0]});

  assert_fixed_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b11) |-> (prg_addr[15:14] == 2'b11 && prg_addr[13:0] == cpu_addr[13:0]));

  assert_low_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[15]) |=> $stable(bank_q));

  assert_read_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(bank_q));

  assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prg_en == cpu_addr[15]);

  assert_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nt_sel == (mirror_horiz ? ppu_addr[11] : ppu_addr[10]));
endmodule

bind cart_addr_bank_map cart_addr_bank_map_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .ppu_addr(ppu_addr), .mirror_horiz(mirror_horiz), .prg_addr(prg_addr),
  .prg_en(prg_en), .chr_addr(chr_addr), .nt_sel(nt_sel), .bank_q(bank_q)
);

// File: tb/tb_cart_addr_bank_map.sv
module tb_cart_addr_bank_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        mirror_horiz = 1'b0;
  logic [15:0] prg_addr;
  logic        prg_en;
  logic [14:0] chr_addr;
  logic        nt_sel;

  always #5 clk = ~clk;

  cart_addr_bank_map dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .ppu_addr(ppu_addr), .mirror_horiz(mirror_horiz), .prg_addr(prg_addr),
    .prg_en(prg_en), .chr_addr(chr_addr), .nt_sel(nt_sel)
  );

  typedef struct {
    string       tag;
    logic [15:0] prg;
    logic        en;
    logic [14:0] chr;
    logic        nt;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  logic [3:0] mbank = '0;
  bit drv_done = 0;

  task automatic step(input logic [15:0] a, input logic wr, input logic [13:0] p,
                      input logic horiz, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_addr = a; cpu_wr = wr; ppu_addr = p; mirror_horiz = horiz;
    if (wr && a[15]) mbank = a[3:0];
    e.tag = tag;
    e.prg = {(a[14] ? 2'b11 : mbank[3:2]), a[13:0]};
    e.en  = a[15];
    e.chr = {mbank[1:0], p[12:0]};
    e.nt  = horiz ? p[11] : p[10];
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (q.size() != 0) begin
        e = q.pop_front();
        total++;
        if (prg_addr !== e.prg || prg_en !== e.en || chr_addr !== e.chr || nt_sel !== e.nt) begin
          bad++;
          $display("FAIL %s: got prg=%h en=%b chr=%h nt=%b, expected prg=%h en=%b chr=%h nt=%b",
                   e.tag, prg_addr, prg_en, chr_addr, nt_sel, e.prg, e.en, e.chr, e.nt);
        end
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    total++;
    if (chr_addr !== 15'h0000) begin
      bad++;
      $display("FAIL R1 during reset: chr=%h expected 0000", chr_addr);
    end
    rst_n = 1'b1;
    step(16'h8000, 0, 14'h0000, 0, "R1 reset bank zero");
    step(16'hC000, 0, 14'h0000, 0, "R5 fixed window after reset");
    step(16'h8005, 1, 14'h0123, 0, "R2 R3 R4 write 8005");
    step(16'hA1FF, 0, 14'h1ABC, 0, "R4 switchable window bank 1");
    step(16'hFFFA, 1, 14'h0400, 0, "R2 write FFFA upper bits ignored");
    step(16'hC123, 0, 14'h1FFF, 0, "R5 fixed window with bank 2 latched");
    step(16'h6003, 1, 14'h0000, 0, "R6 write 6003 ignored");
    step(16'h8000, 0, 14'h0155, 0, "R6 bank kept after 6003");
    step(16'h7FFF, 1, 14'h0000, 0, "R6 write 7FFF ignored");
    step(16'h800F, 0, 14'h0000, 0, "R9 read 800F no latch");
    step(16'h9000, 0, 14'h0000, 0, "R9 bank kept after read");
    step(16'h9F3C, 1, 14'h0AAA, 0, "R2 write 9F3C");
    step(16'h4000, 0, 14'h0000, 0, "R7 enable low below 8000");
    step(16'h7FFF, 0, 14'h0000, 0, "R7 enable low at 7FFF");
    step(16'h8000, 0, 14'h0400, 0, "R8 vertical A10 set");
    step(16'h8000, 0, 14'h0800, 0, "R8 vertical A11 set");
    step(16'h8000, 0, 14'h0400, 1, "R8 horizontal A10 set");
    step(16'h8000, 0, 14'h0800, 1, "R8 horizontal A11 set");
    step(16'hBFFF, 1, 14'h1555, 1, "R2 R3 write BFFF");
    step(16'hBFFF, 0, 14'h0000, 0, "R4 window top bank 3");
    step(16'hE000, 1, 14'h0000, 0, "R2 write E000 clears");
    step(16'hBFFF, 0, 14'h1FFF, 0, "R3 R4 bank 0 after clear");
    @(negedge clk);
    @(negedge clk);
    drv_done = 1;
  end

  initial begin : watchdog
    fork
      wait (drv_done && q.size() == 0);
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule